// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Bus Controller

This block is a clocked behavioural model of the control side of a byte-wide one-time-programmable memory. It can serve as a target in a board-level testbench or stand in for the real memory in an FPGA emulation. On each clock edge it samples its inputs. These are an active-low select, an active-low output gate, an address, a write data byte and two logic flags. The flags stand for the high-voltage conditions that a programmer applies: one on the identification address line, and one on the output-gate pin to enable programming. From these inputs the block picks one operating mode and registers the result onto a data bus. The bus is modelled as a data byte plus a drive enable; a low enable means the bus is released.

The storage is a small internal array. Reset leaves every bit of it at one, and programming can only pull bits to zero. A device that is deselected while the programming flag is raised ignores the write data. Several devices can therefore share address, data and programming lines and still receive different contents, because each one is steered by its own select. In identification mode the bus returns one of three bytes: a manufacturer code, a device code, or a fixed continuation code. Each of these bytes has odd parity.

Top module: `otp_rom_ctrl`

## Requirements
- R1: With select low, gate low and both flags clear, the bus is driven one clock edge later with the byte stored at the sampled address.
- R2: With select high and the programming flag clear, the bus is released one edge later, whatever the gate and identification flag are.
- R3: With select low, gate high and the programming flag clear, the bus is released. Whenever the bus is released, the data output reads 0x00.
- R4: After reset, every address reads 0xFF.
- R5: Identification mode needs select low, gate low, the identification flag set, the programming flag clear and address bits 2 and up all zero. In that mode, address bit 1 high returns 0x7F. With bit 1 low, bit 0 low returns the manufacturer code (default 0x13) and bit 0 high returns the device code (default 0xA8).
- R6: If the identification flag is set but any address bit from 2 upward is nonzero, the bus is released.
- R7: Every identifier byte has odd parity, with bit 7 as the parity bit. The two code parameters are checked for this at elaboration.
- R8: With the programming flag set and select low at a clock edge, the byte at the address becomes its old value ANDed with the write data. The bus is released during programming.
- R9: Programming never turns a stored zero back into a one. Programming all ones leaves the byte unchanged.
- R10: With the programming flag set and select high, the array is left unchanged and the bus is released.
- R11: A verify read, made with the programming flag cleared and both enables low, returns the programmed byte exactly as a normal read does.
- R12: While reset is applied, the bus is released and the data output is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also blanks the array |
| addr | input | AW | Byte address; bits 1:0 also pick the identifier byte |
| ce_n | input | 1 | Active-low device select |
| oe_n | input | 1 | Active-low output gate |
| id_hv | input | 1 | High-voltage condition on the identification address line |
| vpp_hv | input | 1 | High-voltage programming condition on the gate pin |
| dq_in | input | 8 | Write data for programming |
| dq_out | output | 8 | Data driven onto the bus |
| dq_oe | output | 1 | Bus drive enable; low means high impedance |

## Verification
Every bus result is registered, so it is due exactly one rising edge after the inputs that cause it. A program operation changes the array at the edge where it is sampled, so a read issued in the very next cycle already sees the new byte. The bench changes inputs on a falling edge, waits for one rising edge, and samples on the next falling edge. Each check therefore lands in the first cycle where the result is due, and never straddles two results. Consecutive reads at different addresses make sure that no stale value from the previous cycle is being observed.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CONT_CODE = 8'h7F;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OUT_OFF,
        MD_READ,
        MD_IDENT,
        MD_PROGRAM,
        MD_INHIBIT
    } otp_mode_e;

    typedef struct packed {
        logic              drive;
        logic [BYTE_W-1:0] data;
    } bus_word_t;

    function automatic logic odd_par(input logic [BYTE_W-1:0] b);
        return ^b;
    endfunction

    function automatic logic [BYTE_W-1:0] id_pick(
        input logic              a1,
        input logic              a0,
        input logic [BYTE_W-1:0] mfr,
        input logic [BYTE_W-1:0] dev
    );
        if (a1) return CONT_CODE;
        return a0 ? dev : mfr;
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_rom_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          id_hv,
    input  logic          vpp_hv,
    input  logic [AW-1:0] addr,
    output otp_mode_e     mode
);
    logic upper_clear;

    assign upper_clear = (addr[AW-1:2] == '0);

    always_comb begin
        if (vpp_hv)
            mode = ce_n ? MD_INHIBIT : MD_PROGRAM;
        else if (ce_n)
            mode = MD_STANDBY;
        else if (oe_n)
            mode = MD_OUT_OFF;
        else if (id_hv)
            mode = upper_clear ? MD_IDENT : MD_OUT_OFF;
        else
            mode = MD_READ;
    end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_rom_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DEPTH-1:0][BYTE_W-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst)
            mem <= '1;
        else if (wr_en)
            mem[addr] <= mem[addr] & din;
    end

    assign rd_data = mem[addr];

    // R9: no stored bit ever goes from zero to one outside reset
    a_r9_clear_only: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((mem & ~$past(mem)) == '0));

    // R10: without a write strobe the array holds its contents
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem));
endmodule

// File: rtl/otp_bus_drive.sv
module otp_bus_drive
    import otp_rom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  otp_mode_e         mode,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] id_byte,
    output logic [BYTE_W-1:0] dq_out,
    output logic              dq_oe
);
    bus_word_t nxt, cur;

    always_comb begin
        nxt = '0;
        case (mode)
            MD_READ:  nxt = '{drive: 1'b1, data: rd_data};
            MD_IDENT: nxt = '{drive: 1'b1, data: id_byte};
            default:  nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign dq_out = cur.data;
    assign dq_oe  = cur.drive;

    // R7: identifier bytes on the bus carry odd parity
    a_r7_id_parity: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == MD_IDENT) |-> (dq_oe && odd_par(dq_out)));

    // R3: a released bus shows zero data
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (dq_out == '0));
endmodule

// File: rtl/otp_rom_ctrl.sv
module otp_rom_ctrl
    import otp_rom_pkg::*;
#(
    parameter int unsigned       AW       = 6,
    parameter logic [BYTE_W-1:0] MFR_CODE = 8'h13,
    parameter logic [BYTE_W-1:0] DEV_CODE = 8'hA8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              id_hv,
    input  logic              vpp_hv,
    input  logic [BYTE_W-1:0] dq_in,
    output logic [BYTE_W-1:0] dq_out,
    output logic              dq_oe
);
    otp_mode_e         mode;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] id_byte;
    logic              wr_en;

    otp_mode_decode #(.AW(AW)) u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .id_hv  (id_hv),
        .vpp_hv (vpp_hv),
        .addr   (addr),
        .mode   (mode)
    );

    assign wr_en   = (mode == MD_PROGRAM);
    assign id_byte = id_pick(addr[1], addr[0], MFR_CODE, DEV_CODE);

    otp_cell_array #(.AW(AW)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .din     (dq_in),
        .rd_data (rd_data)
    );

    otp_bus_drive u_bus (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .rd_data (rd_data),
        .id_byte (id_byte),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    // R7: code parameters must have odd parity
    initial begin
        a_r7_code_parity: assert (odd_par(MFR_CODE) && odd_par(DEV_CODE))
            else $error("identifier code parameters lack odd parity");
    end

    // R1: the bus is only driven after both enables were low with no programming flag
    a_r1_drive_cause: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> $past(!ce_n && !oe_n && !vpp_hv));

    // R2: deselect without programming releases the bus
    a_r2_standby: assert property (@(posedge clk) disable iff (rst)
        (ce_n && !vpp_hv) |=> !dq_oe);

    // R8: programming or inhibit keeps the bus released
    a_r8_prog_quiet: assert property (@(posedge clk) disable iff (rst)
        vpp_hv |=> !dq_oe);
endmodule

// File: tb/otp_rom_ctrl_tb.sv
`timescale 1ns/1ps
module otp_rom_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] addr = '0;
    logic       ce_n = 1'b1, oe_n = 1'b1, id_hv = 1'b0, vpp_hv = 1'b0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_oe;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [7:0] model [64];

    always #2 clk = ~clk;

    otp_rom_ctrl u_dut (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .id_hv(id_hv), .vpp_hv(vpp_hv), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic step(input logic c, input logic o, input logic h,
                        input logic v, input logic [5:0] a, input logic [7:0] d);
        ce_n = c; oe_n = o; id_hv = h; vpp_hv = v; addr = a; dq_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic eoe, input logic [7:0] edat);
        tests++;
        if (dq_oe !== eoe || dq_out !== edat) begin
            fails++;
            $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                     req, dq_oe, dq_out, eoe, edat);
        end
    endtask

    task automatic read_all(input string req);
        for (int a = 63; a >= 0; a--) begin
            step(0, 0, 0, 0, a[5:0], 8'h00);
            chk(req, 1'b1, model[a]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 64; a++) model[a] = 8'hFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R12", 1'b0, 8'h00);
        rst = 1'b0;

        // R4: blank array
        for (int a = 0; a < 64; a++) begin
            step(0, 0, 0, 0, a[5:0], 8'h00);
            chk("R4", 1'b1, 8'hFF);
        end

        // R2 / R3: released bus
        for (int o = 0; o < 2; o++)
            for (int h = 0; h < 2; h++) begin
                step(1, o[0], h[0], 0, 6'd5, 8'h00);
                chk("R2", 1'b0, 8'h00);
                step(0, 1, h[0], 0, 6'd5, 8'h00);
                chk("R3", 1'b0, 8'h00);
            end

        // R8: program a pattern
        for (int a = 0; a < 64; a++) begin
            logic [7:0] d;
            d = 8'(a * 37 + 11) ^ 8'(a << 2);
            step(0, 1, 0, 1, a[5:0], d);
            chk("R8", 1'b0, 8'h00);
            model[a] = model[a] & d;
        end
        read_all("R11");

        // R10: inhibited write with all zeros
        for (int a = 0; a < 64; a++) begin
            step(1, 0, 0, 1, a[5:0], 8'h00);
            chk("R10", 1'b0, 8'h00);
        end
        read_all("R10");

        // R9: writing ones restores nothing, second pattern only clears
        for (int a = 0; a < 64; a++) step(0, 0, 0, 1, a[5:0], 8'hFF);
        read_all("R9");
        for (int a = 0; a < 64; a += 3) begin
            logic [7:0] d;
            d = ~8'(a * 91);
            step(0, 1, 0, 1, a[5:0], d);
            model[a] = model[a] & d;
        end
        read_all("R1");

        // R5 / R7: identifier bytes
        for (int s = 0; s < 4; s++) begin
            logic [7:0] e;
            e = s[1] ? 8'h7F : (s[0] ? 8'hA8 : 8'h13);
            step(0, 0, 1, 0, {4'b0000, s[1:0]}, 8'h00);
            chk("R5", 1'b1, e);
            tests++;
            if (^dq_out !== 1'b1) begin
                fails++;
                $display("FAIL R7: got parity %0b on %02h, expected 1", ^dq_out, dq_out);
            end
            step(1, 0, 1, 0, {4'b0000, s[1:0]}, 8'h00);
            chk("R2", 1'b0, 8'h00);
        end

        // R6: identification with a stray upper address bit
        for (int b = 2; b < 6; b++) begin
            step(0, 0, 1, 0, 6'(1 << b), 8'h00);
            chk("R6", 1'b0, 8'h00);
        end

        // R4 again after a fresh reset
        rst = 1'b1;
        step(1, 1, 0, 0, 6'd0, 8'h00);
        chk("R12", 1'b0, 8'h00);
        rst = 1'b0;
        for (int a = 0; a < 64; a += 7) begin
            step(0, 0, 0, 0, a[5:0], 8'h00);
            chk("R4", 1'b1, 8'hFF);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule